// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a processor's kick line and drops an active-low fault output when no level change arrives on that line within a programmed number of clock cycles. At 1.6 s nominal this is tens of millions of cycles. Either a rising or a falling change restarts the timer. No control input can switch the watchdog off. The kick line is brought into the clock domain through a chain of synchronizer flops. The clock must run faster than 10 MHz so that a 100 ns kick pulse is always sampled.

While the system reset input is high, the timer is held at zero. A fault that was already showing when reset arrived stays visible for a fixed drain window of about 10 µs, then clears. This lets an outside circuit capture the event when the fault output is wired back to the manual-reset input. In that loop, a kick line stuck at one level produces one reset pulse per timeout period. Whenever the supply sits below the battery switchover point, the output is forced low.

Top module: `wdt_kick_monitor`

## Requirements
- R1: After the power-on reset `rst_n` is released, with `below_sw` low, `wdt_fault_n` is high and the timer starts from zero.
- R2: With `sys_rst` low and no kick change, `wdt_fault_n` falls exactly `TIMEOUT_CYCLES` rising edges after `sys_rst` is first sampled low, and not one edge earlier.
- R3: A low-to-high change of `kick`, first sampled at edge k, restarts the timer at edge k+2, so the next fault appears at edge k+2+`TIMEOUT_CYCLES`.
- R4: A high-to-low change of `kick` restarts the timer with the same timing as R3.
- R5: A `kick` pulse only one clock wide still restarts the timer. Its trailing change, sampled one edge later, restarts it again.
- R6: An active fault clears (`wdt_fault_n` high) at edge k+2 after a kick change first sampled at edge k.
- R7: While `sys_rst` is high the timer is held at zero. No fault is raised during reset, however long it lasts.
- R8: While `below_sw` is high, `wdt_fault_n` is low in the same cycle, whatever the timer state and whatever `sys_rst` is.
- R9: If a fault is active when `sys_rst` rises (first sampled at edge 1), `wdt_fault_n` stays low through edge `RELEASE_CYCLES`-1 and is high after edge `RELEASE_CYCLES`. It then stays high for the rest of the reset.
- R10: After a drained reset ends, with `kick` still held constant, the fault returns `TIMEOUT_CYCLES` edges later. Each reset therefore produces one fault period.
- R11: Once raised, the fault stays low without any further edge until a kick change or a reset drain clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, period below 100 ns |
| rst_n | input | 1 | Asynchronous power-on reset of all flops, active low |
| sys_rst | input | 1 | System reset is asserted, active high |
| below_sw | input | 1 | Supply is below the battery switchover point |
| kick | input | 1 | Asynchronous kick line from the processor |
| wdt_fault_n | output | 1 | Watchdog fault, active low |

## Verification
The embedded assertions check the following on every cycle:
- the timer never passes its limit and stays at zero while reset is held;
- a fault rises only when the timer is on its last count;
- a synchronized kick change always zeroes the timer;
- the drain counter stays inside its window;
- a raised fault holds until a kick change or a reset clears it.

Exact latencies need the bench's timed scenarios:
- the two-edge synchronizer delay on each kick polarity;
- a one-cycle kick pulse;
- the exact edge at which the drain window ends;
- the repeating fault in the fault-to-reset loop;
- the forcing of the output by `below_sw`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Bits needed to hold values 0..limit
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Saturating increment that stops at limit
  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

  // True when the counter sits one below the limit: the next step reaches it
  function automatic logic at_last(input int unsigned cur, input int unsigned limit);
    return (cur == limit - 1);
  endfunction

  typedef enum logic [1:0] {
    FLT_CLEAR  = 2'd0,
    FLT_ACTIVE = 2'd1,
    FLT_DRAIN  = 2'd2
  } flt_state_e;

endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic edge_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  // stage 0 samples the asynchronous pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= kick_i;
  end

  // remaining synchronizer stages
  for (genvar g = 1; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  // previous synchronized sample for change detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage_q[LAST];
  end

  assign edge_o = stage_q[LAST] ^ prev_q;

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned TIMEOUT = 32_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic restart_i,
  output logic [wdt_pkg::cnt_width(TIMEOUT)-1:0] cnt_o,
  output logic expire_o
);
  localparam int unsigned CW = wdt_pkg::cnt_width(TIMEOUT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          clear_w;

  assign clear_w = hold_i | restart_i;

  always_comb begin
    if (clear_w) cnt_d = '0;
    else         cnt_d = CW'(wdt_pkg::sat_inc(32'(cnt_q), TIMEOUT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = !clear_w && wdt_pkg::at_last(32'(cnt_q), TIMEOUT);
  assign cnt_o    = cnt_q;

  // R7
  hold_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= TIMEOUT);

endmodule

// File: rtl/wdt_fault_ctrl.sv
module wdt_fault_ctrl #(
  parameter int unsigned RELEASE = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst_i,
  input  logic kick_edge_i,
  input  logic expire_i,
  input  logic below_sw_i,
  output logic fault_n_o,
  output logic fault_active_o
);
  import wdt_pkg::*;

  localparam int unsigned RW = cnt_width(RELEASE);

  flt_state_e    state_q, state_d;
  logic [RW-1:0] rel_q, rel_d;
  logic          drain_done_w;

  assign drain_done_w = at_last(32'(rel_q), RELEASE);

  always_comb begin
    state_d = state_q;
    rel_d   = '0;
    unique case (state_q)
      FLT_CLEAR: begin
        if (expire_i) state_d = FLT_ACTIVE;
      end
      FLT_ACTIVE: begin
        if (kick_edge_i) begin
          state_d = FLT_CLEAR;
        end else if (sys_rst_i) begin
          state_d = FLT_DRAIN;
          rel_d   = RW'(1);
        end
      end
      FLT_DRAIN: begin
        if (kick_edge_i || (sys_rst_i && drain_done_w)) begin
          state_d = FLT_CLEAR;
        end else if (!sys_rst_i) begin
          state_d = FLT_ACTIVE;
        end else begin
          rel_d = RW'(sat_inc(32'(rel_q), RELEASE));
        end
      end
      default: state_d = FLT_CLEAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FLT_CLEAR;
      rel_q   <= '0;
    end else begin
      state_q <= state_d;
      rel_q   <= rel_d;
    end
  end

  assign fault_active_o = (state_q != FLT_CLEAR);
  assign fault_n_o      = !below_sw_i && !fault_active_o;

  // R9
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rel_q) < RELEASE);

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active_o && !kick_edge_i && !sys_rst_i) |=> fault_active_o);

endmodule

// File: rtl/wdt_kick_monitor.sv
module wdt_kick_monitor #(
  parameter int unsigned TIMEOUT_CYCLES = 32_000_000,
  parameter int unsigned RELEASE_CYCLES = 200,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic below_sw,
  input  logic kick,
  output logic wdt_fault_n
);
  localparam int unsigned CW = wdt_pkg::cnt_width(TIMEOUT_CYCLES);

  logic          kick_edge_w;
  logic          expire_w;
  logic          fault_active_w;
  logic [CW-1:0] timer_cnt_w;

  wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_i (kick),
    .edge_o (kick_edge_w)
  );

  wdt_timer #(.TIMEOUT(TIMEOUT_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (sys_rst),
    .restart_i (kick_edge_w),
    .cnt_o     (timer_cnt_w),
    .expire_o  (expire_w)
  );

  wdt_fault_ctrl #(.RELEASE(RELEASE_CYCLES)) u_fault (
    .clk            (clk),
    .rst_n          (rst_n),
    .sys_rst_i      (sys_rst),
    .kick_edge_i    (kick_edge_w),
    .expire_i       (expire_w),
    .below_sw_i     (below_sw),
    .fault_n_o      (wdt_fault_n),
    .fault_active_o (fault_active_w)
  );

  // R2
  fault_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_active_w) && !$past(fault_active_w)) |->
      (32'($past(timer_cnt_w)) == TIMEOUT_CYCLES - 1));

  // R3
  edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_edge_w |=> (timer_cnt_w == '0));

  // R7
  no_fault_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && !fault_active_w) |=> !fault_active_w);

endmodule

// File: tb/tb_wdt_kick_monitor.sv
module tb_wdt_kick_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 40;
  localparam int RL = 6;

  logic clk = 1'b0;
  logic rst_n, sys_rst, below_sw, kick;
  logic wdt_fault_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    val;
    string req;
  } exp_t;

  exp_t sb[$];

  wdt_kick_monitor #(
    .TIMEOUT_CYCLES(T),
    .RELEASE_CYCLES(RL),
    .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .below_sw(below_sw), .kick(kick), .wdt_fault_n(wdt_fault_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // driver side: expect value v after n more rising edges
  task automatic expect_in(input int n, input bit v, input string r);
    exp_t e;
    int idx;
    e.at = cyc + n; e.val = v; e.req = r;
    idx = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > e.at) begin idx = i; break; end
    end
    sb.insert(idx, e);
  endtask

  task automatic check_now(input bit v, input string r);
    checks++;
    if (wdt_fault_n !== v) begin
      failures++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", r, cyc, wdt_fault_n, v);
    end
  endtask

  // monitor: compare scoreboard entries due this cycle
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.at != cyc || wdt_fault_n !== e.val) begin
        failures++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b", e.req, cyc, wdt_fault_n, e.val);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain_sb();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sys_rst = 1'b1; below_sw = 1'b0; kick = 1'b0;
    step(3);
    #1 check_now(1'b1, "R1");
    rst_n = 1'b1;
    step(1);
    // R7: long reset, no fault
    expect_in(T + 10, 1'b1, "R7");
    drain_sb();
    // R1/R2: release system reset, fault after T edges
    step(1); sys_rst = 1'b0;
    expect_in(1, 1'b1, "R1");
    expect_in(T - 1, 1'b1, "R2");
    expect_in(T, 1'b0, "R2");
    expect_in(T + 10, 1'b0, "R11");
    drain_sb();
    // R6/R3: rising kick clears fault and restarts timer
    step(1); kick = 1'b1;
    expect_in(2, 1'b0, "R6");
    expect_in(3, 1'b1, "R6");
    expect_in(T + 2, 1'b1, "R3");
    expect_in(T + 3, 1'b0, "R3");
    drain_sb();
    // R4: falling kick
    step(1); kick = 1'b0;
    expect_in(3, 1'b1, "R6");
    expect_in(T + 2, 1'b1, "R4");
    expect_in(T + 3, 1'b0, "R4");
    drain_sb();
    // R5: one-cycle pulse
    step(1); kick = 1'b1;
    expect_in(3, 1'b1, "R5");
    expect_in(T + 3, 1'b1, "R5");
    expect_in(T + 4, 1'b0, "R5");
    step(1); kick = 1'b0;
    drain_sb();
    // R8: below switchover forces low
    step(1); kick = 1'b1;
    expect_in(3, 1'b1, "R6");
    drain_sb();
    step(4); below_sw = 1'b1;
    #1 check_now(1'b0, "R8");
    step(2);
    #1 check_now(1'b0, "R8");
    below_sw = 1'b0;
    #1 check_now(1'b1, "R8");
    // let it time out with kick held high
    while (wdt_fault_n) @(negedge clk);
    step(2);
    // R9: reset with pending fault drains after RL edges
    sys_rst = 1'b1;
    expect_in(RL - 1, 1'b0, "R9");
    expect_in(RL, 1'b1, "R9");
    expect_in(RL + 30, 1'b1, "R9");
    drain_sb();
    // R10: reset released with kick stuck, fault returns
    sys_rst = 1'b0;
    expect_in(T - 1, 1'b1, "R10");
    expect_in(T, 1'b0, "R10");
    drain_sb();
    // loop back: fault drives reset
    sys_rst = 1'b1;
    expect_in(RL - 1, 1'b0, "R10");
    expect_in(RL, 1'b1, "R10");
    drain_sb();
    step(5); sys_rst = 1'b0;
    expect_in(T, 1'b0, "R10");
    drain_sb();
    // R8 during reset
    sys_rst = 1'b1; below_sw = 1'b1;
    #1 check_now(1'b0, "R8");
    step(RL + 4);
    #1 check_now(1'b0, "R8");
    below_sw = 1'b0;
    #1 check_now(1'b1, "R9");
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 200000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
    end
    if (sb.size() > 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule